// File: doc/BRIEF.md
# Peripheral Enable Address Decoder

This block keeps a small enable register that switches five on-chip targets on or off: two CAN controllers, two internal RAM blocks and a real-time clock. A register bus writes and reads it. From the register and a 24-bit bus address, the decoder works out combinationally which target the access belongs to. An enabled target claims its fixed address window. A disabled one either hands its window to external memory or, if other enables still hold the window shared, leaves the access with no target at all.

The decoder drives a one-hot select vector. Bits 0 to 4 select internal targets and bit 5 selects external memory. A separate no-target flag covers accesses that nobody claims. The block also drives four pin-release flags that tell the port logic when the pins of a disabled CAN controller are free for general-purpose use.

Top module: `periph_addr_decoder`

## Requirements
- R1: After reset the enable register reads 0x0005. Enable bit 0 is CAN1, bit 1 is CAN2, bit 2 is RAM1, bit 3 is RAM2 and bit 4 is the RTC, so CAN1 and RAM1 start enabled.
- R2: A write with `reg_we` high stores `reg_wdata[4:0]` at the clock edge. The new value shows on `reg_rdata` and in the decode from the next cycle on. Writes to bits 15:5 have no effect, and those bits always read 0.
- R3: Addresses 0x00E000 to 0x00E7FF set `sel[2]` (RAM1) when bit 2 is set. Otherwise they set `sel[5]` (external).
- R4: Addresses 0x00C000 to 0x00DFFF set `sel[3]` (RAM2) when bit 3 is set. Otherwise they set `sel[5]`.
- R5: Addresses 0x00EF00 to 0x00EFFF set `sel[0]` (CAN1) when bit 0 is set. With bit 0 clear they set `sel[5]` only if bit 1 is also clear.
- R6: Addresses 0x00EE00 to 0x00EEFF set `sel[1]` (CAN2) when bit 1 is set. With bit 1 clear they set `sel[5]` only if bit 0 is also clear.
- R7: Addresses 0x00EC00 to 0x00ECFF set `sel[4]` (RTC) when bit 4 is set. With bit 4 clear they set `sel[5]` only if bits 0 and 1 are both clear.
- R8: Any address outside the five windows, including any address with bits 23:16 non-zero, sets `sel[5]`.
- R9: A disabled window whose external condition fails drives `sel` to all zeros and raises `no_target`.
- R10: For every address and register value, exactly one of the seven signals `sel[5:0]` and `no_target` is high.
- R11: `pin_free[1]` and `pin_free[2]` (port pins 4.5 and 4.6) are high exactly when bit 0 is clear. `pin_free[0]` and `pin_free[3]` (pins 4.4 and 4.7) are high exactly when bit 1 is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, bits 15:5 zero |
| bus_addr | input | 24 | Access address to decode |
| sel | output | 6 | One-hot select: 0 CAN1, 1 CAN2, 2 RAM1, 3 RAM2, 4 RTC, 5 external |
| no_target | output | 1 | Access falls in a window that nobody claims |
| pin_free | output | 4 | Pin-release flags for port pins 4.4 to 4.7, bit i = pin 4.(4+i) |

## Verification
Address decoding has zero latency: `sel`, `no_target` and `pin_free` follow `bus_addr` within the same cycle. A register write reaches `reg_rdata`, the decode and the pin flags one clock edge after `reg_we` is sampled. The bench drives inputs just after the falling edge and compares every output with its behavioural model at the next falling edge. The model updates its own register copy at the rising edge in between, so each check sees exactly one register update.

// File: rtl/pdec_pkg.sv
// Package: shared sizes, target indices and the fixed address windows.
// Assumes windows are aligned to their power-of-two size and do not overlap.
package pdec_pkg;
    localparam int ADDR_W  = 24;
    localparam int REG_W   = 16;
    localparam int N_TGT   = 5;
    localparam int SEL_W   = N_TGT + 1;
    localparam int EXT_IDX = N_TGT;
    localparam int N_PIN   = 4;
    localparam logic [REG_W-1:0] EN_RESET = 16'h0005;

    // Target index doubles as the enable bit position.
    typedef enum int {
        T_CAN1 = 0,
        T_CAN2 = 1,
        T_RAM1 = 2,
        T_RAM2 = 3,
        T_RTC  = 4
    } tgt_e;

    // Base address of the window owned by target i.
    function automatic logic [ADDR_W-1:0] win_base(input int i);
        case (i)
            T_CAN1:  win_base = 24'h00EF00;
            T_CAN2:  win_base = 24'h00EE00;
            T_RAM1:  win_base = 24'h00E000;
            T_RAM2:  win_base = 24'h00C000;
            default: win_base = 24'h00EC00;
        endcase
    endfunction

    // log2 of the window size for target i.
    function automatic int win_log2(input int i);
        case (i)
            T_RAM1:  win_log2 = 11;
            T_RAM2:  win_log2 = 13;
            default: win_log2 = 8;
        endcase
    endfunction
endpackage

// File: rtl/pdec_enreg.sv
// Enable register: holds the low EN_W bits written over the register bus.
// Assumes a synchronous active-low reset; upper read bits are tied to zero.
module pdec_enreg #(
    parameter int                 REG_W   = 16,
    parameter int                 EN_W    = 5,
    parameter logic [REG_W-1:0]   RST_VAL = 16'h0005
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [EN_W-1:0]  en_q,
    output logic [REG_W-1:0] rdata
);
    // Capture writable bits; reset to the power-on enables.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= RST_VAL[EN_W-1:0];
        else if (we)
            en_q <= wdata[EN_W-1:0];
    end

    // Zero-extend the stored bits for read-back.
    always_comb begin
        rdata           = '0;
        rdata[EN_W-1:0] = en_q;
    end
endmodule

// File: rtl/pdec_winmatch.sv
// Window matcher: one hit bit per target window, compared on the address
// bits above the window size. Assumes windows from pdec_pkg are aligned.
module pdec_winmatch
    import pdec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int N  = N_TGT
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  hit
);
    for (genvar i = 0; i < N; i++) begin : g_win
        localparam int          SH   = win_log2(i);
        localparam logic [AW-1:0] BASE = win_base(i);
        // Compare the upper address bits against the window base.
        assign hit[i] = (addr[AW-1:SH] == BASE[AW-1:SH]);
    end
endmodule

// File: rtl/pdec_route.sv
// Router: turns window hits and enables into a one-hot select, the
// no-target flag and the pin-release flags. Assumes at most one hit.
module pdec_route
    import pdec_pkg::*;
#(
    parameter int N = N_TGT
) (
    input  logic [N-1:0]     hit,
    input  logic [N-1:0]     en,
    output logic [N:0]       sel,
    output logic             no_target,
    output logic [N_PIN-1:0] pin_free
);
    logic [N-1:0] fallback;
    logic         any_hit;
    logic         ext_fb;

    // Per-window condition under which a disabled window goes external.
    always_comb begin
        fallback         = '1;
        fallback[T_CAN1] = !en[T_CAN2];
        fallback[T_CAN2] = !en[T_CAN1];
        fallback[T_RTC]  = !en[T_CAN1] && !en[T_CAN2];
    end

    // Pick the internal target, the external path or nothing.
    always_comb begin
        sel     = '0;
        ext_fb  = 1'b0;
        any_hit = |hit;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && en[i])
                sel[i] = 1'b1;
            if (hit[i] && !en[i] && fallback[i])
                ext_fb = 1'b1;
        end
        sel[N]    = !any_hit || ext_fb;
        no_target = any_hit && !(|sel);
    end

    // Release CAN pins when the owning controller is off (bit i = pin 4.(4+i)).
    always_comb begin
        pin_free[0] = !en[T_CAN2];
        pin_free[1] = !en[T_CAN1];
        pin_free[2] = !en[T_CAN1];
        pin_free[3] = !en[T_CAN2];
    end
endmodule

// File: rtl/periph_addr_decoder.sv
// Top: peripheral-enable register plus combinational address decode.
// Assumes a single clock and a synchronous active-low reset.
module periph_addr_decoder
    import pdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [SEL_W-1:0]  sel,
    output logic              no_target,
    output logic [N_PIN-1:0]  pin_free
);
    logic [N_TGT-1:0] en_q;
    logic [N_TGT-1:0] hit;

    pdec_enreg #(
        .REG_W  (REG_W),
        .EN_W   (N_TGT),
        .RST_VAL(EN_RESET)
    ) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .wdata(reg_wdata),
        .en_q (en_q),
        .rdata(reg_rdata)
    );

    pdec_winmatch #(
        .AW(ADDR_W),
        .N (N_TGT)
    ) u_win (
        .addr(bus_addr),
        .hit (hit)
    );

    pdec_route #(
        .N(N_TGT)
    ) u_route (
        .hit      (hit),
        .en       (en_q),
        .sel      (sel),
        .no_target(no_target),
        .pin_free (pin_free)
    );
endmodule

// File: rtl/pdec_checker.sv
// Checker: port-level properties of the decoder, bound to the top module.
module pdec_checker
    import pdec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SEL_W-1:0]  sel,
    input logic              no_target,
    input logic [N_PIN-1:0]  pin_free
);
    logic in_ram1, in_ram2, in_can1, in_rtc, outside;
    assign in_ram1 = (bus_addr >= 24'h00E000) && (bus_addr <= 24'h00E7FF);
    assign in_ram2 = (bus_addr >= 24'h00C000) && (bus_addr <= 24'h00DFFF);
    assign in_can1 = (bus_addr >= 24'h00EF00) && (bus_addr <= 24'h00EFFF);
    assign in_rtc  = (bus_addr >= 24'h00EC00) && (bus_addr <= 24'h00ECFF);
    assign outside = (bus_addr < 24'h00C000) || (bus_addr > 24'h00EFFF);

    assert_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata[N_TGT-1:0] == $past(reg_wdata[N_TGT-1:0])));
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:N_TGT] == '0);
    assert_ram1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ram1 |-> (reg_rdata[2] ? sel[2] : sel[EXT_IDX]));
    assert_ram2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ram2 |-> (reg_rdata[3] ? sel[3] : sel[EXT_IDX]));
    assert_can1_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_can1 && !reg_rdata[0] && reg_rdata[1]) |-> no_target);
    assert_rtc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rtc && reg_rdata[4]) |-> sel[4]);
    assert_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> sel[EXT_IDX]);
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({sel, no_target}));
    assert_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_free[1] == !reg_rdata[0]) && (pin_free[0] == !reg_rdata[1]));
endmodule

bind periph_addr_decoder pdec_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .bus_addr (bus_addr),
    .sel      (sel),
    .no_target(no_target),
    .pin_free (pin_free)
);

// File: tb/sim_periph_addr_decoder.sv
// Bench: behavioural reference model compared at every falling edge.
module sim_periph_addr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [23:0] bus_addr = '0;
    logic [5:0]  sel;
    logic        no_target;
    logic [3:0]  pin_free;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    logic [4:0] m_en;

    always #4 clk = ~clk;

    periph_addr_decoder u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_addr(bus_addr), .sel(sel),
        .no_target(no_target), .pin_free(pin_free)
    );

    // Model register: R1 reset value, R2 write of the low five bits.
    always @(posedge clk) begin
        if (!rst_n) m_en <= 5'h05;
        else if (reg_we) m_en <= reg_wdata[4:0];
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<=100000", cycles);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h addr=%06h en=%02h", req, act, exp, bus_addr, m_en);
        end
    endtask

    // Expected select (bit 6 = no_target) and the requirement the address covers.
    task automatic model(input logic [4:0] e, input int a, output int exp, output string req);
        if (a >= 'hC000 && a <= 'hDFFF) begin
            req = "R4"; exp = e[3] ? 8 : 32;
        end else if (a >= 'hE000 && a <= 'hE7FF) begin
            req = "R3"; exp = e[2] ? 4 : 32;
        end else if (a >= 'hEC00 && a <= 'hECFF) begin
            req = "R7"; exp = e[4] ? 16 : ((!e[0] && !e[1]) ? 32 : 64);
        end else if (a >= 'hEE00 && a <= 'hEEFF) begin
            req = "R6"; exp = e[1] ? 2 : (!e[0] ? 32 : 64);
        end else if (a >= 'hEF00 && a <= 'hEFFF) begin
            req = "R5"; exp = e[0] ? 1 : (!e[1] ? 32 : 64);
        end else begin
            req = "R8"; exp = 32;
        end
        if (exp == 64) req = "R9";
    endtask

    // Compare every output with the model for the inputs now applied.
    task automatic check_all();
        int exp;
        string req;
        model(m_en, int'(bus_addr), exp, req);
        chk(req, {no_target, sel}, exp);
        chk("R10", $countones({sel, no_target}), 1);
        chk("R2", reg_rdata, {11'h0, m_en});
        chk("R11", pin_free, {~m_en[1], ~m_en[0], ~m_en[0], ~m_en[1]});
    endtask

    int addrs[18] = '{'h00C000, 'h00BFFF, 'h00DFFF, 'h00E000, 'h00E7FF, 'h00E800,
                      'h00EBFF, 'h00EC00, 'h00ECFF, 'h00ED00, 'h00EE00, 'h00EEFF,
                      'h00EF00, 'h00EFFF, 'h00F000, 'h01E000, 'h000000, 'hFFFFFF};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", reg_rdata, 16'h0005);
        check_all();
        for (int e = 0; e < 32; e++) begin
            reg_we = 1'b1;
            reg_wdata = {((e % 2) == 1) ? 11'h7FF : 11'h2A5, 5'(e)};
            @(negedge clk);
            reg_we = 1'b0;
            chk("R2", reg_rdata, e);
            for (int k = 0; k < 18; k++) begin
                bus_addr = 24'(addrs[k]);
                @(negedge clk);
                check_all();
            end
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule